// File: doc/BRIEF.md
# Four-Wire Converter Serial Slave Port

This block is the slave end of the serial port on a data converter that has separate data-in and data-out pins. An external master drives a chip select, a direction line, a serial clock and serial data. The direction line, not the chip select, frames each transfer. With the direction line low, the master writes an 8-bit control byte. With it high, the master reads a 10-bit conversion result. The result is shifted out most significant bit first, on a data-out pin that can be switched to high impedance.

All four serial inputs are brought into a faster system clock domain through synchroniser chains. The direction line, chip select and serial clock are then edge-detected there. A small state machine decides when a transfer may start and when it has ended. It has five states:
- `ST_IDLE`: waiting for a transfer.
- `ST_READ`: driving the result out.
- `ST_RD_END`: the read has finished and the block waits for the direction line to drop.
- `ST_WRITE`: collecting control bits.
- `ST_WR_END`: the byte is complete and the block waits for the direction line to rise.

The transitions are:
- `ST_IDLE` goes to `ST_READ` on a direction-line rising edge while selected.
- `ST_IDLE` goes to `ST_WRITE` while the direction line is low and the block is selected.
- `ST_READ` goes to `ST_RD_END` on chip select rising or the direction line falling.
- `ST_RD_END` goes to `ST_IDLE` once the direction line is low.
- `ST_WRITE` goes to `ST_WR_END` on the eighth captured bit. It goes to `ST_READ` on a direction-line rising edge while selected, and to `ST_IDLE` on that edge while deselected or whenever chip select is high.
- `ST_WR_END` goes to `ST_READ` on a direction-line rising edge while selected, and to `ST_IDLE` on that edge while deselected.

A result of the conversion core is snapshotted on every read start. The chip select may be tied low when the bus is not shared.

Top module: `adc_serial_slave`

## Requirements
- R1: After reset, `dout_oe` is 0, `ctrl_byte` is 0 and `ctrl_load` is 0.
- R2: A rising edge of `rdwr` while `cs_n` is low sets `dout_oe` to 1 and puts result bit 9 on `dout`.
- R3: During a read, each `sclk` falling edge that follows at least one `sclk` rising edge of that read moves `dout` to the next lower result bit. Ten bits are sent, most significant first.
- R4: Once bit 0 is on `dout`, further `sclk` edges leave `dout` at bit 0 while `dout_oe` stays 1.
- R5: While `rdwr` stays high, pausing `sclk` keeps the bit position. A read split into bursts delivers the same word, and a master may stop after 8 bits and then start a normal write.
- R6: `dout_oe` returns to 0 on whichever comes first: `cs_n` rising or `rdwr` falling.
- R7: A new read starts only on a new `rdwr` rising edge while `cs_n` is low. Re-selecting with `rdwr` already high, or an `rdwr` rising edge while `cs_n` is high, leaves `dout_oe` at 0.
- R8: On a write, `din` is sampled on the first 8 `sclk` rising edges, first bit into bit 7. After the eighth bit, `ctrl_byte` takes the value and `ctrl_load` pulses high for exactly one cycle. `dout_oe` stays 0 throughout the write.
- R9: `sclk` rising edges after the eighth of a write change neither `ctrl_byte` nor `ctrl_load`.
- R10: A second write is accepted only after `rdwr` has gone high and then low again. Bytes clocked in without that toggle are ignored.
- R11: The result is captured when the read starts. Changes on `result` during the read do not alter the bits shifted out.
- R12: All read and write behaviour holds with `cs_n` held low permanently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than `sclk` |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select (may be tied low) |
| rdwr | input | 1 | Direction line: high = read, low = control write |
| sclk | input | 1 | Serial clock from the master |
| din | input | 1 | Serial data in |
| result | input | RES_W | Conversion result offered for readout |
| dout | output | 1 | Serial data out value |
| dout_oe | output | 1 | Output enable for the data-out pad driver (0 = high impedance) |
| ctrl_byte | output | CTRL_W | Last accepted control byte |
| ctrl_load | output | 1 | One-cycle strobe when `ctrl_byte` is updated |

## Verification
The hardest situation to reach is the set of re-arm refusals. These are a second write without a direction toggle, a re-select with the direction line already high, and a direction rise while deselected. In each of them nothing observable happens, so the stimulus first completes a legal transfer to leave the machine in an end state. It then replays the forbidden move and watches `ctrl_byte`, the strobe count and `dout_oe`. After that, a legal toggle proves the machine was only waiting. A read split by a long pause and a read clocked past its tenth bit are also driven, because only a master that misbehaves in timing reaches those paths.

// File: rtl/adc_slave_pkg.sv
package adc_slave_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_RD_END,
        ST_WRITE,
        ST_WR_END
    } slave_state_e;

endpackage

// File: rtl/sync_chain.sv
module sync_chain #(
    parameter int           N       = 4,
    parameter int           STAGES  = 2,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_in,
    output logic [N-1:0] sync_out
);

    logic [N-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= RST_VAL;
        end else begin
            stage_q[0] <= async_in;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/tx_shift.sv
module tx_shift #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         shift,
    input  logic [W-1:0] data,
    output logic         bit_o
);

    localparam int CW = $clog2(W);

    logic [W-1:0]  sh_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q  <= '0;
            cnt_q <= '0;
        end else if (load) begin
            sh_q  <= data;
            cnt_q <= '0;
        end else if (shift && (cnt_q < CW'(W - 1))) begin
            sh_q  <= {sh_q[W-2:0], 1'b0};
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign bit_o = sh_q[W-1];

endmodule

// File: rtl/rx_capture.sv
module rx_capture #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         sample,
    input  logic         din,
    output logic         last,
    output logic [W-1:0] word_o
);

    localparam int CW = $clog2(W);

    logic [W-2:0]  sh_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q  <= '0;
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (sample) begin
            sh_q  <= {sh_q[W-3:0], din};
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign last   = sample && !clear && (cnt_q == CW'(W - 1));
    assign word_o = {sh_q, din};

endmodule

// File: rtl/adc_serial_slave.sv
module adc_serial_slave
    import adc_slave_pkg::*;
#(
    parameter int RES_W       = 10,
    parameter int CTRL_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              rdwr,
    input  logic              sclk,
    input  logic              din,
    input  logic [RES_W-1:0]  result,
    output logic              dout,
    output logic              dout_oe,
    output logic [CTRL_W-1:0] ctrl_byte,
    output logic              ctrl_load
);

    // synchronised inputs: {din, sclk, rdwr, cs_n}; chip select resets deselected
    logic [3:0] sync_lvl;
    logic       cs_s, rw_s, sclk_s, din_s;
    logic       cs_prev, rw_prev, sclk_prev;
    logic       cs_rise, rw_rise, rw_fall, sclk_rise, sclk_fall;

    sync_chain #(
        .N       (4),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (4'b0001)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({din, sclk, rdwr, cs_n}),
        .sync_out (sync_lvl)
    );

    assign {din_s, sclk_s, rw_s, cs_s} = sync_lvl;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_prev   <= 1'b1;
            rw_prev   <= 1'b0;
            sclk_prev <= 1'b0;
        end else begin
            cs_prev   <= cs_s;
            rw_prev   <= rw_s;
            sclk_prev <= sclk_s;
        end
    end

    assign cs_rise   =  cs_s   && !cs_prev;
    assign rw_rise   =  rw_s   && !rw_prev;
    assign rw_fall   = !rw_s   &&  rw_prev;
    assign sclk_rise =  sclk_s && !sclk_prev;
    assign sclk_fall = !sclk_s &&  sclk_prev;

    slave_state_e state_q, state_d;
    logic         seen_rise_q;
    logic         wr_last;
    logic [CTRL_W-1:0] wr_word;
    logic         rd_load, rd_shift;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (rw_rise && !cs_s)      state_d = ST_READ;
                else if (!rw_s && !cs_s)   state_d = ST_WRITE;
            end
            ST_READ: begin
                if (cs_rise || rw_fall)    state_d = ST_RD_END;
            end
            ST_RD_END: begin
                if (!rw_s)                 state_d = ST_IDLE;
            end
            ST_WRITE: begin
                if (rw_rise)               state_d = cs_s ? ST_IDLE : ST_READ;
                else if (cs_s)             state_d = ST_IDLE;
                else if (wr_last)          state_d = ST_WR_END;
            end
            ST_WR_END: begin
                if (rw_rise)               state_d = cs_s ? ST_IDLE : ST_READ;
            end
            default:                       state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // output and datapath control registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_byte   <= '0;
            ctrl_load   <= 1'b0;
            seen_rise_q <= 1'b0;
        end else begin
            ctrl_load <= 1'b0;
            if (wr_last && state_d == ST_WR_END) begin
                ctrl_byte <= wr_word;
                ctrl_load <= 1'b1;
            end
            if (rd_load)                              seen_rise_q <= 1'b0;
            else if (state_q == ST_READ && sclk_rise) seen_rise_q <= 1'b1;
        end
    end

    assign rd_load  = (state_q != ST_READ) && (state_d == ST_READ);
    assign rd_shift = (state_q == ST_READ) && seen_rise_q && sclk_fall;
    assign dout_oe  = (state_q == ST_READ);

    tx_shift #(
        .W (RES_W)
    ) u_tx (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (rd_load),
        .shift (rd_shift),
        .data  (result),
        .bit_o (dout)
    );

    rx_capture #(
        .W (CTRL_W)
    ) u_rx (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (state_q != ST_WRITE),
        .sample (state_q == ST_WRITE && sclk_rise),
        .din    (din_s),
        .last   (wr_last),
        .word_o (wr_word)
    );

endmodule

// File: rtl/adc_serial_slave_chk.sv
module adc_serial_slave_chk #(
    parameter int CTRL_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              dout,
    input logic              dout_oe,
    input logic [CTRL_W-1:0] ctrl_byte,
    input logic              ctrl_load,
    input logic              rw_rise,
    input logic              rw_fall,
    input logic              cs_rise,
    input logic              sclk_fall
);

    // R8: strobe lasts a single cycle
    p_load_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_load |=> !ctrl_load);

    // R8: no output drive while a byte is being accepted
    p_no_drive_on_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_load |-> !dout_oe);

    // R9: control byte moves only together with its strobe
    p_byte_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_load |-> $stable(ctrl_byte));

    // R2: drive begins only after a direction-line rising edge
    p_start_on_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dout_oe) |-> $past(rw_rise));

    // R6: deselect or direction drop releases the pin next cycle
    p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_rise || rw_fall) |=> !dout_oe);

    // R3: data out moves only after a serial clock falling edge
    p_bit_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_oe && $past(dout_oe) && !$past(sclk_fall)) |-> $stable(dout));

endmodule

bind adc_serial_slave adc_serial_slave_chk #(
    .CTRL_W (CTRL_W)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .dout      (dout),
    .dout_oe   (dout_oe),
    .ctrl_byte (ctrl_byte),
    .ctrl_load (ctrl_load),
    .rw_rise   (rw_rise),
    .rw_fall   (rw_fall),
    .cs_rise   (cs_rise),
    .sclk_fall (sclk_fall)
);

// File: tb/test_adc_serial_slave.sv
`timescale 1ns/1ps
module test_adc_serial_slave;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b0;
    logic       rdwr = 1'b0;
    logic       sclk = 1'b0;
    logic       din = 1'b0;
    logic [9:0] result = '0;
    logic       dout, dout_oe, ctrl_load;
    logic [7:0] ctrl_byte;

    int total = 0;
    int bad = 0;
    int loads = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    adc_serial_slave i_adc_serial_slave (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .rdwr      (rdwr),
        .sclk      (sclk),
        .din       (din),
        .result    (result),
        .dout      (dout),
        .dout_oe   (dout_oe),
        .ctrl_byte (ctrl_byte),
        .ctrl_load (ctrl_load)
    );

    always @(posedge clk) if (ctrl_load) loads++;

    // {result, control byte}
    localparam logic [17:0] VEC [5] = '{
        {10'h3FF, 8'hA5},
        {10'h000, 8'hFF},
        {10'h2AB, 8'h3C},
        {10'h155, 8'h01},
        {10'h201, 8'h80}
    };

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, input int nclk);
        for (int i = 0; i < nclk; i++) begin
            if (i < 8) din = b[7-i];
            else       din = ~din;
            tick(3);
            sclk = 1'b1;
            tick(6);
            sclk = 1'b0;
            tick(3);
        end
        tick(8);
    endtask

    task automatic start_read();
        rdwr = 1'b1;
        tick(8);
    endtask

    task automatic clock_bit(output logic b);
        sclk = 1'b1;
        tick(6);
        sclk = 1'b0;
        tick(6);
        b = dout;
    endtask

    task automatic read_word(input int n, output logic [9:0] w);
        logic b;
        w = '0;
        w[9] = dout;
        for (int i = 1; i < n; i++) begin
            clock_bit(b);
            w[9-i] = b;
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(4 * 150000);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=0 expected=1");
        finish_run();
    end

    initial begin
        logic [9:0] w;
        logic       b;
        int         lc;

        tick(5);
        rst_n = 1'b1;
        tick(6);
        check(dout_oe == 1'b0, "R1", "dout_oe after reset", dout_oe, 0);
        check(ctrl_byte == 8'h00, "R1", "ctrl_byte after reset", ctrl_byte, 0);
        check(loads == 0, "R1", "ctrl_load pulses after reset", loads, 0);

        // table walk, cs_n held low throughout (R12)
        for (int k = 0; k < 5; k++) begin
            result = VEC[k][17:8];
            lc = loads;
            send_byte(VEC[k][7:0], 8);
            check(ctrl_byte == VEC[k][7:0], "R8", "control byte (R12 cs low)",
                  ctrl_byte, VEC[k][7:0]);
            check(loads == lc + 1, "R8", "strobe count", loads, lc + 1);
            start_read();
            check(dout_oe == 1'b1, "R2", "drive on read start", dout_oe, 1);
            check(dout == VEC[k][17], "R2", "first bit is bit 9", dout, VEC[k][17]);
            read_word(10, w);
            check(w == VEC[k][17:8], "R3", "10-bit word (R12 cs low)", w, VEC[k][17:8]);
            rdwr = 1'b0;
            tick(8);
            check(dout_oe == 1'b0, "R6", "release on direction fall", dout_oe, 0);
        end

        // R9: extra clocks after eighth bit
        lc = loads;
        send_byte(8'h5A, 12);
        check(ctrl_byte == 8'h5A, "R9", "byte after 12 clocks", ctrl_byte, 8'h5A);
        check(loads == lc + 1, "R9", "single strobe for 12 clocks", loads, lc + 1);

        // R10: second byte without toggle ignored
        send_byte(8'hC3, 8);
        check(ctrl_byte == 8'h5A, "R10", "byte without toggle", ctrl_byte, 8'h5A);
        check(loads == lc + 1, "R10", "no strobe without toggle", loads, lc + 1);

        // R5: split read with long pause
        result = 10'h1E7;
        start_read();
        w = '0;
        w[9] = dout;
        for (int i = 1; i < 5; i++) begin
            clock_bit(b);
            w[9-i] = b;
        end
        tick(40);
        for (int i = 5; i < 10; i++) begin
            clock_bit(b);
            w[9-i] = b;
        end
        check(w == 10'h1E7, "R5", "split read word", w, 10'h1E7);

        // R4: hold bit 0 after ten bits
        for (int i = 0; i < 3; i++) begin
            clock_bit(b);
            check(b == 1'b1 && dout_oe, "R4", "hold last bit", b, 1);
        end

        // R6: deselect releases pin with direction still high
        cs_n = 1'b1;
        tick(6);
        check(dout_oe == 1'b0, "R6", "release on chip select rise", dout_oe, 0);

        // R7: reselect with direction already high does not restart
        cs_n = 1'b0;
        tick(8);
        check(dout_oe == 1'b0, "R7", "reselect without new edge", dout_oe, 0);

        // R7: direction rise while deselected does not start
        cs_n = 1'b1;
        rdwr = 1'b0;
        tick(8);
        rdwr = 1'b1;
        tick(8);
        check(dout_oe == 1'b0, "R7", "rise while deselected", dout_oe, 0);
        cs_n = 1'b0;
        tick(8);
        check(dout_oe == 1'b0, "R7", "select after deselected rise", dout_oe, 0);

        // R10: after a high-low toggle the next write is taken
        rdwr = 1'b0;
        tick(8);
        lc = loads;
        send_byte(8'h96, 8);
        check(ctrl_byte == 8'h96, "R10", "byte after toggle", ctrl_byte, 8'h96);
        check(loads == lc + 1, "R10", "strobe after toggle", loads, lc + 1);

        // R11: snapshot at read start
        result = 10'h155;
        start_read();
        result = 10'h2AA;
        read_word(10, w);
        check(w == 10'h155, "R11", "snapshot word", w, 10'h155);

        // R5: early stop after 8 bits, then a normal write
        rdwr = 1'b0;
        tick(8);
        send_byte(8'h11, 8);
        result = 10'h0F3;
        start_read();
        read_word(8, w);
        check(w[9:2] == 8'h3C, "R5", "8-bit early stop", w[9:2], 8'h3C);
        rdwr = 1'b0;
        tick(6);
        check(dout_oe == 1'b0, "R6", "release mid-read", dout_oe, 0);
        tick(4);
        send_byte(8'h81, 8);
        check(ctrl_byte == 8'h81, "R5", "write after early stop", ctrl_byte, 8'h81);

        finish_run();
    end

endmodule